// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block gathers eight interrupt request lines, latches each rising edge as a pending request and picks one winner by fixed priority. Line 0 has the highest priority and line 7 the lowest. When a pending, unmasked request outranks the work already in service, the block raises its interrupt output toward the processor. The processor answers with two acknowledge pulses. The first pulse moves the winner from pending to in-service. The second pulse returns an 8-bit vector, built from a programmable base and the winning level.

Software controls the block through a one-cycle register write strobe with a 3-bit select. The select chooses one of five actions: write the mask, issue a non-specific end of interrupt, issue a specific end of interrupt, change the special mask mode, or write the configuration. The configuration holds the vector base and the automatic end-of-interrupt flag.

A parameter picks the master or the slave role. In the master role, a level request from a cascaded slave appears on line 2, and the automatic end-of-interrupt setting takes effect. In the slave role, that setting is ignored.

No interface of this block carries a data stream with back-pressure. The write port is accepted on every cycle it is strobed. The vector appears as a one-cycle `vec_valid` strobe. The processor's acknowledge timing already paces it, so it has no ready input.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is pending, `isr_o` is 0, `int_out` and `vec_valid` are 0, and the mask is all zero, so every line is enabled.
- R2: A rising edge on `irq_in[n]` latches a pending request. A line that is held high produces no new request once its request has been acknowledged; a fresh low-to-high edge is needed.
- R3: Priority is fixed, with a lower index winning. Outside special mask mode, `int_out` is 1 only when the best unmasked pending level is numerically lower than the lowest set bit of `isr_o`, or when `isr_o` is 0.
- R4: Mask bit n (select 0, `wr_data[n]`) blocks line n from raising `int_out`. A request that arrives while masked stays latched and is served after unmasking.
- R5: On the rising edge of the first acknowledge pulse, the winner's bit in `isr_o` sets and its pending bit clears. On the rise of the second pulse, `vec_valid` is high for exactly one cycle with `vec_data = {base, level}`. If nothing wins, level 7 is returned and `isr_o` is unchanged.
- R6: A non-specific end of interrupt (select 1) clears the lowest-numbered set bit of `isr_o`.
- R7: A specific end of interrupt (select 2) clears only the `isr_o` bit named by `wr_data[2:0]`. If that bit is already clear, nothing changes.
- R8: A mode write (select 3) with `wr_data[1:0] = 2'b11` enters special mask mode. `2'b10` leaves it. When `wr_data[1]` is 0, the mode is unchanged.
- R9: In special mask mode, any unmasked pending request raises `int_out`, whatever `isr_o` holds.
- R10: In special mask mode, a non-specific end of interrupt skips `isr_o` bits whose mask bit is set and clears the lowest-numbered unmasked set bit.
- R11: In the master role with automatic end of interrupt on (select 4, `wr_data[0] = 1`; `wr_data[7:3]` is the base), a non-specific end of interrupt is performed on the falling edge of the second acknowledge pulse.
- R12: In the slave role, the automatic end-of-interrupt flag has no effect, and `isr_o` keeps the acknowledged bit.
- R13: In the master role, a high `slave_req` acts as a pending request on line 2. Mask bit 2 blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Edge-triggered request lines, line 0 highest priority |
| slave_req | input | 1 | Level request from a cascaded slave (master role only) |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 3 | Write action: 0 mask, 1 non-specific EOI, 2 specific EOI, 3 mode, 4 configuration |
| wr_data | input | 8 | Write data |
| inta | input | 1 | Acknowledge level from the processor, two pulses per interrupt |
| int_out | output | 1 | Interrupt request toward the processor |
| vec_valid | output | 1 | One-cycle strobe marking `vec_data` |
| vec_data | output | 8 | Vector: base in bits 7:3, level in bits 2:0 |
| isr_o | output | 8 | In-service bits |

## Verification
The checker module watches every cycle for the following:
- a vector strobe never lasts more than one cycle;
- a first acknowledge pulse adds at most one in-service bit;
- a fully masked controller never interrupts;
- a specific end of interrupt clears exactly its named bit;
- a non-specific end of interrupt in special mask mode leaves masked in-service bits alone.

Other behaviours depend on a prepared history, so only the directed scenarios can show them. These include the priority order against in-service levels, requests that stay latched through masking, the need for a fresh edge, and the timing of the automatic end of interrupt. They also include the slave role ignoring that setting and cascade gating through mask bit 2.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_NSEOI = 3'd1,
    SEL_SEOI  = 3'd2,
    SEL_MODE  = 3'd3,
    SEL_CFG   = 3'd4
  } wsel_e;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_WAIT2 = 2'd1,
    ACK_IN2   = 2'd2
  } ack_st_e;
endpackage

// File: rtl/pic_first_set.sv
// Finds the lowest-numbered set bit, which is the highest priority.
module pic_first_set #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
// Latches rising edges of the request lines until each one is acknowledged.
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = lines & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= lines;
      irr    <= (irr & ~clr) | rise;
    end
  end
endmodule

// File: rtl/pic_ack_seq.sv
// Tracks the two-pulse acknowledge and emits one strobe per phase.
module pic_ack_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic inta,
  output logic take1,
  output logic give2,
  output logic done2
);
  import pic_pkg::*;

  ack_st_e st_q;
  logic    inta_q;
  logic    rise;
  logic    fall;

  assign rise  = inta & ~inta_q;
  assign fall  = ~inta & inta_q;
  assign take1 = rise && (st_q == ACK_IDLE);
  assign give2 = rise && (st_q == ACK_WAIT2);
  assign done2 = fall && (st_q == ACK_IN2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q <= 1'b0;
      st_q   <= ACK_IDLE;
    end else begin
      inta_q <= inta;
      unique case (st_q)
        ACK_IDLE:  if (take1) st_q <= ACK_WAIT2;
        ACK_WAIT2: if (give2) st_q <= ACK_IN2;
        ACK_IN2:   if (done2) st_q <= ACK_IDLE;
        default:   st_q <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_resolve.sv
// Decides whether a pending request may interrupt, and which level wins.
module pic_resolve #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] irr_eff,
  input  logic [N-1:0] imr,
  input  logic [N-1:0] isr,
  input  logic         smm,
  output logic         grant,
  output logic [W-1:0] win_lvl
);
  logic [N-1:0] req;
  logic         req_hit;
  logic         isr_hit;
  logic [W-1:0] isr_top;

  assign req = irr_eff & ~imr;

  pic_first_set #(.N(N)) u_req_pick (.vec(req), .hit(req_hit), .idx(win_lvl));
  pic_first_set #(.N(N)) u_isr_pick (.vec(isr), .hit(isr_hit), .idx(isr_top));

  always_comb begin
    if (smm) grant = req_hit;
    else     grant = req_hit && (!isr_hit || (win_lvl < isr_top));
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IRQ     = 8,
  parameter int VEC_W     = 8,
  parameter int IS_MASTER = 1,
  parameter int CAS_LINE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             slave_req,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             inta,
  output logic             int_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data,
  output logic [N_IRQ-1:0] isr_o
);
  import pic_pkg::*;

  localparam int LVL_W  = $clog2(N_IRQ);
  localparam int BASE_W = VEC_W - LVL_W;
  localparam bit IS_M   = (IS_MASTER != 0);
  localparam logic [N_IRQ-1:0] CAS_BIT = N_IRQ'(1) << CAS_LINE;

  logic [N_IRQ-1:0]  irr;
  logic [N_IRQ-1:0]  irr_eff;
  logic [N_IRQ-1:0]  cas_vec;
  logic [N_IRQ-1:0]  isr_q;
  logic [N_IRQ-1:0]  imr_q;
  logic              smm_q;
  logic              aeoi_q;
  logic [BASE_W-1:0] base_q;
  logic [LVL_W-1:0]  ack_lvl_q;
  logic              vec_valid_q;
  logic [VEC_W-1:0]  vec_q;

  logic              grant;
  logic [LVL_W-1:0]  win_lvl;
  logic              take1, give2, done2;
  logic              ack_evt;
  logic              aeoi_eff;
  logic [N_IRQ-1:0]  eoi_src;
  logic              eoi_hit;
  logic [LVL_W-1:0]  eoi_lvl;
  logic              do_nseoi, do_seoi;
  logic [N_IRQ-1:0]  isr_set, isr_clr;
  logic              wr_mask, wr_mode, wr_cfg;

  // Cascade input: only a master sees the slave's level request.
  assign cas_vec  = (IS_M && slave_req) ? CAS_BIT : '0;
  assign irr_eff  = irr | cas_vec;
  assign aeoi_eff = IS_M && aeoi_q;

  pic_req_latch #(.N(N_IRQ)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .clr(isr_set), .irr(irr)
  );

  pic_resolve #(.N(N_IRQ)) u_resolve (
    .irr_eff(irr_eff), .imr(imr_q), .isr(isr_q), .smm(smm_q),
    .grant(grant), .win_lvl(win_lvl)
  );

  pic_ack_seq u_ack (
    .clk(clk), .rst_n(rst_n), .inta(inta),
    .take1(take1), .give2(give2), .done2(done2)
  );

  assign ack_evt = take1 | give2 | done2;

  // Non-specific EOI target: special mask mode hides masked in-service bits.
  assign eoi_src = smm_q ? (isr_q & ~imr_q) : isr_q;
  pic_first_set #(.N(N_IRQ)) u_eoi_pick (.vec(eoi_src), .hit(eoi_hit), .idx(eoi_lvl));

  assign wr_mask  = wr_en && (wr_sel == SEL_MASK);
  assign wr_mode  = wr_en && (wr_sel == SEL_MODE);
  assign wr_cfg   = wr_en && (wr_sel == SEL_CFG);
  assign do_seoi  = wr_en && (wr_sel == SEL_SEOI);
  assign do_nseoi = (wr_en && (wr_sel == SEL_NSEOI)) || (done2 && aeoi_eff);

  always_comb begin
    isr_clr = '0;
    if (do_nseoi && eoi_hit) isr_clr = isr_clr | (N_IRQ'(1) << eoi_lvl);
    if (do_seoi)             isr_clr = isr_clr | (N_IRQ'(1) << wr_data[LVL_W-1:0]);
    isr_set = (take1 && grant) ? (N_IRQ'(1) << win_lvl) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      imr_q     <= '0;
      smm_q     <= 1'b0;
      aeoi_q    <= 1'b0;
      base_q    <= '0;
      ack_lvl_q <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (wr_mask) imr_q <= wr_data[N_IRQ-1:0];
      if (wr_mode && wr_data[1]) smm_q <= wr_data[0];
      if (wr_cfg) begin
        base_q <= wr_data[VEC_W-1:LVL_W];
        aeoi_q <= wr_data[0];
      end
      if (take1) ack_lvl_q <= grant ? win_lvl : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      vec_valid_q <= give2;
      if (give2) vec_q <= {base_q, ack_lvl_q};
    end
  end

  assign int_out   = grant;
  assign vec_valid = vec_valid_q;
  assign vec_data  = vec_q;
  assign isr_o     = isr_q;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8,
  localparam int LVL_W = $clog2(N_IRQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [VEC_W-1:0] wr_data,
  input logic             int_out,
  input logic             vec_valid,
  input logic [N_IRQ-1:0] isr_o,
  input logic [N_IRQ-1:0] imr_q,
  input logic             smm_q,
  input logic             take1,
  input logic             ack_evt
);
  logic [N_IRQ-1:0] seoi_bit;
  logic             seoi_wr, nseoi_wr;

  assign seoi_bit = N_IRQ'(1) << wr_data[LVL_W-1:0];
  assign seoi_wr  = wr_en && (wr_sel == 3'd2) && !ack_evt;
  assign nseoi_wr = wr_en && (wr_sel == 3'd1) && !ack_evt;

  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R5

  AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    take1 |=> ($countones(isr_o & ~$past(isr_o)) <= 1)); // R5

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&imr_q) |-> !int_out); // R4

  AST_SEOI_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    seoi_wr |=> (isr_o == ($past(isr_o) & ~$past(seoi_bit)))); // R7

  AST_SMM_EOI_KEEPS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (nseoi_wr && smm_q) |=> ((isr_o & imr_q) == ($past(isr_o) & $past(imr_q)))); // R10
endmodule

bind prio_irq_ctrl pic_chk #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .int_out(int_out), .vec_valid(vec_valid), .isr_o(isr_o), .imr_q(imr_q),
  .smm_q(smm_q), .take1(take1), .ack_evt(ack_evt)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] irq = '0;
  logic       slave_req = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       inta = 1'b0;
  logic       sel_slv = 1'b0;

  logic       m_int, m_vv, s_int, s_vv;
  logic [7:0] m_vd, m_isr, s_vd, s_isr;
  logic       int_v, vv_v;
  logic [7:0] vd_v, isr_v;

  prio_irq_ctrl #(.IS_MASTER(1)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq & {8{~sel_slv}}), .slave_req(slave_req),
    .wr_en(wr_en & ~sel_slv), .wr_sel(wr_sel), .wr_data(wr_data), .inta(inta & ~sel_slv),
    .int_out(m_int), .vec_valid(m_vv), .vec_data(m_vd), .isr_o(m_isr)
  );

  prio_irq_ctrl #(.IS_MASTER(0)) i_prio_irq_ctrl_slv (
    .clk(clk), .rst_n(rst_n), .irq_in(irq & {8{sel_slv}}), .slave_req(1'b0),
    .wr_en(wr_en & sel_slv), .wr_sel(wr_sel), .wr_data(wr_data), .inta(inta & sel_slv),
    .int_out(s_int), .vec_valid(s_vv), .vec_data(s_vd), .isr_o(s_isr)
  );

  assign int_v = sel_slv ? s_int : m_int;
  assign vv_v  = sel_slv ? s_vv  : m_vv;
  assign vd_v  = sel_slv ? s_vd  : m_vd;
  assign isr_v = sel_slv ? s_isr : m_isr;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic do_reset();
    irq = '0; slave_req = 1'b0; wr_en = 1'b0; inta = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    wr_sel = sel; wr_data = data; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int line);
    irq[line] = 1'b1;
    @(negedge clk);
    irq[line] = 1'b0;
    @(negedge clk);
  endtask

  // Two acknowledge pulses; returns ISR after pulse one, vector strobe and data.
  task automatic ack(output logic [7:0] isr1, output logic vv, output logic [7:0] vd,
                     output logic vv_after);
    inta = 1'b1; @(negedge clk);
    isr1 = isr_v;
    inta = 1'b0; @(negedge clk);
    inta = 1'b1; @(negedge clk);
    vv = vv_v; vd = vd_v;
    inta = 1'b0; @(negedge clk);
    vv_after = vv_v;
  endtask

  logic [7:0] a_isr, a_vd;
  logic       a_vv, a_vv2;

  task automatic t_reset();
    do_reset();
    check("R1 int_out", int_v, 0);
    check("R1 isr", isr_v, 0);
    check("R1 vec_valid", vv_v, 0);
    pulse(7);
    check("R1 mask clear at reset", int_v, 1);
  endtask

  task automatic t_edge();
    do_reset();
    irq[4] = 1'b1; @(negedge clk);
    check("R2 edge latched", int_v, 1);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R2 vector level", a_vd, 8'h04);
    wr(3'd1, 8'h00);
    check("R2 held line no new request", int_v, 0);
    irq[4] = 1'b0; @(negedge clk);
    irq[4] = 1'b1; @(negedge clk);
    check("R2 fresh edge", int_v, 1);
    irq[4] = 1'b0;
  endtask

  task automatic t_prio();
    do_reset();
    irq[6] = 1'b1; irq[3] = 1'b1; @(negedge clk);
    irq = '0; @(negedge clk);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R3 winner is lower index", a_vd, 8'h03);
    check("R3 isr", isr_v, 8'h08);
    check("R3 lower level blocked by isr", int_v, 0);
    pulse(1);
    check("R3 higher level interrupts", int_v, 1);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R3 nested vector", a_vd, 8'h01);
    check("R3 nested isr", isr_v, 8'h0A);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd0, 8'h20);
    pulse(5);
    check("R4 masked line quiet", int_v, 0);
    wr(3'd0, 8'h00);
    check("R4 latched served after unmask", int_v, 1);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R4 vector", a_vd, 8'h05);
  endtask

  task automatic t_ack();
    do_reset();
    wr(3'd4, 8'hA8);
    pulse(2);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R5 isr after pulse one", a_isr, 8'h04);
    check("R5 vec_valid", a_vv, 1);
    check("R5 vec_data", a_vd, 8'hAA);
    check("R5 vec_valid one cycle", a_vv2, 0);
    check("R5 request cleared", int_v, 0);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R5 no winner level 7", a_vd, 8'hAF);
    check("R5 no winner isr unchanged", isr_v, 8'h04);
  endtask

  task automatic setup_isr_2_5();
    do_reset();
    pulse(5);
    ack(a_isr, a_vv, a_vd, a_vv2);
    pulse(2);
    ack(a_isr, a_vv, a_vd, a_vv2);
  endtask

  task automatic t_nseoi();
    setup_isr_2_5();
    check("R6 setup isr", isr_v, 8'h24);
    wr(3'd1, 8'h00);
    check("R6 clears highest priority", isr_v, 8'h20);
    wr(3'd1, 8'h00);
    check("R6 clears remaining", isr_v, 8'h00);
  endtask

  task automatic t_seoi();
    setup_isr_2_5();
    wr(3'd2, 8'h05);
    check("R7 named bit only", isr_v, 8'h04);
    wr(3'd2, 8'h06);
    check("R7 clear bit no change", isr_v, 8'h04);
  endtask

  task automatic t_smm();
    do_reset();
    pulse(1);
    ack(a_isr, a_vv, a_vd, a_vv2);
    pulse(4);
    check("R9 normal mode blocked", int_v, 0);
    wr(3'd3, 8'h03);
    check("R9 special mask grants", int_v, 1);
    wr(3'd3, 8'h01);
    check("R8 mode kept when select bit low", int_v, 1);
    wr(3'd3, 8'h02);
    check("R8 mode left", int_v, 0);
  endtask

  task automatic t_smm_eoi();
    do_reset();
    pulse(2);
    ack(a_isr, a_vv, a_vd, a_vv2);
    pulse(1);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R10 setup isr", isr_v, 8'h06);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h00);
    check("R10 masked bit skipped", isr_v, 8'h02);
    wr(3'd3, 8'h02);
    wr(3'd1, 8'h00);
    check("R10 normal mode clears masked bit", isr_v, 8'h00);
  endtask

  task automatic t_aeoi();
    do_reset();
    wr(3'd4, 8'h01);
    pulse(3);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R11 isr set by pulse one", a_isr, 8'h08);
    check("R11 auto clear after pulse two", isr_v, 8'h00);
  endtask

  task automatic t_slave();
    do_reset();
    sel_slv = 1'b1;
    wr(3'd4, 8'h01);
    pulse(3);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R12 slave vector", a_vd, 8'h03);
    check("R12 slave ignores auto EOI", isr_v, 8'h08);
    sel_slv = 1'b0;
  endtask

  task automatic t_cascade();
    do_reset();
    slave_req = 1'b1; @(negedge clk);
    check("R13 slave request on line 2", int_v, 1);
    wr(3'd0, 8'h04);
    check("R13 mask bit 2 blocks slave", int_v, 0);
    wr(3'd0, 8'h00);
    ack(a_isr, a_vv, a_vd, a_vv2);
    check("R13 cascade vector", a_vd, 8'h02);
    check("R13 cascade isr", isr_v, 8'h04);
    slave_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_edge();
    t_prio();
    t_mask();
    t_ack();
    t_nseoi();
    t_seoi();
    t_smm();
    t_smm_eoi();
    t_aeoi();
    t_slave();
    t_cascade();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule